// File: doc/BRIEF.md
# Dual-Channel UART Host Register Front End

This block is the processor-facing register file of a two-channel serial port. A host reaches it over a parallel bus with an 8-bit data path and a 3-bit register address. Every bus cycle is framed by an active-low read or write strobe, and two active-low select lines choose the channel or channels. Each channel holds a small register set:
- a line-control register, whose top bit opens the divisor latch;
- divisor low and high bytes;
- a scratch byte;
- two stub registers that stand in for the data and interrupt-enable registers.

The strobes and the bus fields come from an asynchronous host. They pass through a synchroniser into the block's clock domain. A write takes effect when its strobe is released. The read data is captured once, when the read strobe is first seen low, and is then held until the strobe goes high again. The bus is strobe-framed, so it has no back-pressure: a cycle always completes, and the host paces itself through the strobe widths.

Two behaviours set this block apart:
- **Broadcast write.** With both selects low, a write updates the addressed register in both channels at once. A read with both selects low is refused: it returns 0x00 and raises an error flag.
- **Identity readout.** If a channel's divisor is all zero and the divisor latch is open, its two divisor addresses return a fixed identity byte and a revision byte instead of the stored bytes.

Reset is active high. It is filtered, so only a pulse that lasts a minimum number of clock cycles clears the registers.

Top module: `duart_host_regs`

## Requirements
- R1: Channel selection decodes the pair {sel_b_n, sel_a_n} as follows:
  - 2'b10 (only A low) targets channel A.
  - 2'b01 (only B low) targets channel B.
  - A write with one channel selected changes only that channel's registers.
- R2: With both selects low (2'b00), a write stores the same byte at the same address in both channels.
- R3: A read with both selects low drives rdata = 0x00, with rdata_oe = 1 and rd_conflict = 1, for as long as the read strobe stays low. A read with a single channel selected drives rd_conflict = 0.
- R4: When line-control bit 7 is 1 and both divisor bytes of the selected channel are 0x00, the reads return fixed codes:
  - address 1 returns 0x12;
  - address 0 returns 0x01.
- R5: When line-control bit 7 is 1 and the divisor is not all zero, address 0 returns the stored divisor low byte and address 1 returns the stored divisor high byte.
- R6: When line-control bit 7 is 0, addresses 0 and 1 reach two plain stub registers that are separate from the divisor bytes. Address 3 is the line-control register and address 7 is the scratch register. All four registers are readable back.
- R7: A write commits only after the synchronised write strobe returns high. It uses the address, data and select values from the last cycle in which the strobe was low.
- R8: rdata is captured on the first synchronised cycle in which the read strobe is low and stays unchanged while the strobe remains low. After the strobe returns high, rdata_oe and rd_conflict go to 0 and rdata goes to 0x00.
- R9: With both selects high (2'b11), a read leaves rdata_oe = 0 and rdata = 0x00, and a write changes no register.
- R10: A reset pulse held for at least RST_MIN_CYC clock edges clears every register of both channels to 0x00, so the identity read of R4 works straight after reset. A shorter pulse changes nothing.
- R11: Addresses 2, 4, 5 and 6 read as 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high reset request; filtered by a minimum pulse length |
| sel_a_n | input | 1 | Active-low select of channel A |
| sel_b_n | input | 1 | Active-low select of channel B |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data to the host, held while the read strobe is low |
| rdata_oe | output | 1 | High while a selected read drives rdata |
| rd_conflict | output | 1 | High while a read with both channels selected is in progress |

## Verification
The main function is exercised with four select patterns:
- Single-A and single-B writes show whether the decode keeps the channels apart.
- Broadcast writes show whether both channels receive the same byte.
- Deselected cycles show that writes are ignored and that reads leave the output enable low.

The divisor bytes are read in three states, which together separate the identity substitution from plain storage:
- all zero with the latch open;
- non-zero with the latch open;
- with the latch closed.

Long write strobes, held reads and reset pulses just below and at the minimum length test the timing around the strobe edges and the reset filter.

// File: rtl/duart_host_pkg.sv
package duart_host_pkg;
  localparam int NCH = 2;
  localparam int DW  = 8;
  localparam int AW  = 3;
  localparam int DLAB_BIT = DW - 1;

  localparam logic [DW-1:0] ID_DEVICE   = 8'h12;
  localparam logic [DW-1:0] ID_REVISION = 8'h01;

  localparam logic [AW-1:0] AD_DIV_LO = 3'd0;
  localparam logic [AW-1:0] AD_DIV_HI = 3'd1;
  localparam logic [AW-1:0] AD_LCTL   = 3'd3;
  localparam logic [AW-1:0] AD_SCR    = 3'd7;

  typedef struct packed {
    logic [DW-1:0] dat_stub;
    logic [DW-1:0] ien_stub;
    logic [DW-1:0] div_lo;
    logic [DW-1:0] div_hi;
    logic [DW-1:0] lctl;
    logic [DW-1:0] scr;
  } chan_regs_t;

  typedef struct packed {
    logic          rd_n;
    logic          wr_n;
    logic [NCH-1:0] sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } bus_smp_t;

  localparam bus_smp_t BUS_IDLE = '{rd_n: 1'b1, wr_n: 1'b1, sel_n: '1,
                                   addr: '0, wdata: '0};

  function automatic logic [DW-1:0] chan_read(input chan_regs_t r,
                                              input logic [AW-1:0] a);
    logic latch_open;
    logic div_zero;
    logic [DW-1:0] v;
    latch_open = r.lctl[DLAB_BIT];
    div_zero   = (r.div_lo == '0) && (r.div_hi == '0);
    case (a)
      AD_DIV_LO: v = !latch_open ? r.dat_stub : (div_zero ? ID_REVISION : r.div_lo);
      AD_DIV_HI: v = !latch_open ? r.ien_stub : (div_zero ? ID_DEVICE : r.div_hi);
      AD_LCTL:   v = r.lctl;
      AD_SCR:    v = r.scr;
      default:   v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/duart_rst_filter.sv
module duart_rst_filter #(
  parameter int MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  output logic rst_int
);
  logic [MIN_CYC-1:0] hist;

  always_ff @(posedge clk) begin
    hist <= (hist << 1) | MIN_CYC'(rst);
  end

  assign rst_int = &hist;
endmodule

// File: rtl/duart_bus_sync.sv
module duart_bus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_int,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst_int) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
  import duart_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_int,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  output chan_regs_t    regs
);
  always_ff @(posedge clk) begin
    if (rst_int) begin
      regs <= '0;
    end else if (we) begin
      case (waddr)
        AD_DIV_LO: if (regs.lctl[DLAB_BIT]) regs.div_lo <= wdata;
                   else regs.dat_stub <= wdata;
        AD_DIV_HI: if (regs.lctl[DLAB_BIT]) regs.div_hi <= wdata;
                   else regs.ien_stub <= wdata;
        AD_LCTL:   regs.lctl <= wdata;
        AD_SCR:    regs.scr  <= wdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/duart_host_regs.sv
module duart_host_regs
  import duart_host_pkg::*;
#(
  parameter int RST_MIN_CYC = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_a_n,
  input  logic          sel_b_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          rd_conflict
);
  localparam int SMP_W = $bits(bus_smp_t);

  logic     rst_int;
  bus_smp_t raw_smp, cur_smp, prev_smp;
  logic     wr_rise, rd_fall;
  logic [NCH-1:0] rd_sel_n, wr_sel_n;
  logic [AW-1:0]  rd_addr, wr_addr;
  chan_regs_t     ch_regs [NCH];
  logic [DW-1:0]  rd_value;
  logic           rd_any, rd_both;

  duart_rst_filter #(.MIN_CYC(RST_MIN_CYC)) u_rst (
    .clk(clk), .rst(rst), .rst_int(rst_int)
  );

  assign raw_smp = '{rd_n: rd_n, wr_n: wr_n, sel_n: {sel_b_n, sel_a_n},
                     addr: addr, wdata: wdata};

  duart_bus_sync #(.W(SMP_W), .STAGES(SYNC_STAGES), .IDLE(BUS_IDLE)) u_sync (
    .clk(clk), .rst_int(rst_int), .d(raw_smp), .q(cur_smp)
  );

  always_ff @(posedge clk) begin
    if (rst_int) prev_smp <= BUS_IDLE;
    else         prev_smp <= cur_smp;
  end

  // The previous sample is the last one with the write strobe low.
  assign wr_rise  = !prev_smp.wr_n && cur_smp.wr_n;
  assign rd_fall  = !cur_smp.rd_n && prev_smp.rd_n;
  assign wr_sel_n = prev_smp.sel_n;
  assign wr_addr  = prev_smp.addr;
  assign rd_sel_n = cur_smp.sel_n;
  assign rd_addr  = cur_smp.addr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    duart_chan_regs u_regs (
      .clk(clk),
      .rst_int(rst_int),
      .we(wr_rise && !wr_sel_n[c]),
      .waddr(wr_addr),
      .wdata(prev_smp.wdata),
      .regs(ch_regs[c])
    );
  end

  assign rd_any  = (rd_sel_n != '1);
  assign rd_both = (rd_sel_n == '0);

  always_comb begin
    rd_value = '0;
    if (rd_any && !rd_both) begin
      for (int c = 0; c < NCH; c++)
        if (!rd_sel_n[c]) rd_value = chan_read(ch_regs[c], rd_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_int) begin
      rdata       <= '0;
      rdata_oe    <= 1'b0;
      rd_conflict <= 1'b0;
    end else if (rd_fall) begin
      rdata       <= rd_value;
      rdata_oe    <= rd_any;
      rd_conflict <= rd_both;
    end else if (cur_smp.rd_n) begin
      rdata       <= '0;
      rdata_oe    <= 1'b0;
      rd_conflict <= 1'b0;
    end
  end
endmodule

// File: rtl/duart_host_regs_chk.sv
module duart_host_regs_chk
  import duart_host_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           rst_int,
  input logic           wr_rise,
  input logic           rd_fall,
  input logic [NCH-1:0] rd_sel_n,
  input logic [NCH-1:0] wr_sel_n,
  input logic [AW-1:0]  rd_addr,
  input logic [AW-1:0]  wr_addr,
  input logic [DW-1:0]  rdata,
  input logic           rdata_oe,
  input logic           rd_conflict,
  input chan_regs_t     regs_a,
  input chan_regs_t     regs_b
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst_int;

  p_commit_on_release_r7: assert property (@(posedge clk)
    disable iff (rst || rst_int || !armed)
    !$stable(regs_a) |-> $past(wr_rise && !wr_sel_n[0]));

  p_bcast_scratch_r2: assert property (@(posedge clk)
    disable iff (rst || rst_int || !armed)
    (wr_rise && wr_sel_n == 2'b00 && wr_addr == AD_SCR) |=> (regs_a.scr == regs_b.scr));

  p_conflict_zero_r3: assert property (@(posedge clk)
    disable iff (rst || rst_int || !armed)
    rd_conflict |-> (rdata_oe && rdata == '0));

  p_read_hold_r8: assert property (@(posedge clk)
    disable iff (rst || rst_int || !armed)
    (rdata_oe && $past(rdata_oe) && !rd_fall) |-> $stable(rdata));

  p_deselect_quiet_r9: assert property (@(posedge clk)
    disable iff (rst || rst_int || !armed)
    (rd_fall && rd_sel_n == 2'b11) |=> (!rdata_oe && rdata == '0));

  p_ident_code_r4: assert property (@(posedge clk)
    disable iff (rst || rst_int || !armed)
    (rd_fall && rd_sel_n == 2'b10 && rd_addr == AD_DIV_HI && regs_a.lctl[DLAB_BIT]
     && regs_a.div_lo == '0 && regs_a.div_hi == '0) |=> (rdata_oe && rdata == ID_DEVICE));
endmodule

bind duart_host_regs duart_host_regs_chk u_chk (
  .clk(clk), .rst(rst), .rst_int(rst_int),
  .wr_rise(wr_rise), .rd_fall(rd_fall),
  .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
  .rd_addr(rd_addr), .wr_addr(wr_addr),
  .rdata(rdata), .rdata_oe(rdata_oe), .rd_conflict(rd_conflict),
  .regs_a(ch_regs[0]), .regs_b(ch_regs[1])
);

// File: tb/duart_host_regs_test.sv
module duart_host_regs_test;
  localparam int RMIN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_a_n = 1'b1, sel_b_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe, rd_conflict;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mchk_on = 0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  duart_host_regs #(.RST_MIN_CYC(RMIN), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .rd_conflict(rd_conflict)
  );

  // ---------------- behavioural reference ----------------
  typedef struct packed {
    logic rd; logic wr; logic [1:0] sel; logic [2:0] a; logic [7:0] d;
  } smp_t;
  localparam smp_t IDLE_S = '{rd: 1'b1, wr: 1'b1, sel: 2'b11, a: 3'd0, d: 8'd0};

  logic [7:0] m_dat [2], m_ien [2], m_dll [2], m_dlm [2], m_lcr [2], m_scr [2];
  logic [7:0] e_data = '0;
  logic e_oe = 1'b0, e_err = 1'b0;
  smp_t h1 = IDLE_S, h2 = IDLE_S, h3 = IDLE_S;
  int rcnt = 0;

  function automatic logic [7:0] m_read(input int c, input logic [2:0] a);
    bit open_l = m_lcr[c][7];
    bit zero_d = (m_dll[c] == 0) && (m_dlm[c] == 0);
    if (a == 3) return m_lcr[c];
    if (a == 7) return m_scr[c];
    if (a == 0) return open_l ? (zero_d ? 8'h01 : m_dll[c]) : m_dat[c];
    if (a == 1) return open_l ? (zero_d ? 8'h12 : m_dlm[c]) : m_ien[c];
    return 8'h00;
  endfunction

  task automatic m_write(input int c, input logic [2:0] a, input logic [7:0] d);
    if (a == 3) m_lcr[c] = d;
    else if (a == 7) m_scr[c] = d;
    else if (a == 0) begin if (m_lcr[c][7]) m_dll[c] = d; else m_dat[c] = d; end
    else if (a == 1) begin if (m_lcr[c][7]) m_dlm[c] = d; else m_ien[c] = d; end
  endtask

  always @(posedge clk) begin : ref_model
    smp_t now_s;
    bit rint;
    now_s = '{rd: rd_n, wr: wr_n, sel: {sel_b_n, sel_a_n}, a: addr, d: wdata};
    rint = (rcnt >= RMIN);
    rcnt = rst ? ((rcnt < 100) ? rcnt + 1 : rcnt) : 0;
    if (rint) begin
      for (int c = 0; c < 2; c++) begin
        m_dat[c] = 0; m_ien[c] = 0; m_dll[c] = 0; m_dlm[c] = 0; m_lcr[c] = 0; m_scr[c] = 0;
      end
      e_data = 0; e_oe = 0; e_err = 0;
      h1 = IDLE_S; h2 = IDLE_S; h3 = IDLE_S;
    end else begin
      if (!h2.rd && h3.rd) begin
        if (h2.sel == 2'b11) begin e_data = 0; e_oe = 0; e_err = 0; end
        else if (h2.sel == 2'b00) begin e_data = 0; e_oe = 1; e_err = 1; end
        else begin e_data = m_read(h2.sel[0] ? 1 : 0, h2.a); e_oe = 1; e_err = 0; end
      end else if (h2.rd) begin
        e_data = 0; e_oe = 0; e_err = 0;
      end
      if (!h3.wr && h2.wr) begin
        for (int c = 0; c < 2; c++) if (!h3.sel[c]) m_write(c, h3.a, h3.d);
      end
      h3 = h2; h2 = h1; h1 = now_s;
    end
  end

  always @(negedge clk) begin
    if (mchk_on) begin
      checks++;
      if (rdata !== e_data || rdata_oe !== e_oe || rd_conflict !== e_err) begin
        errors++;
        $display("FAIL %s model compare: act data=%h oe=%b err=%b exp data=%h oe=%b err=%b",
                 cur_req, rdata, rdata_oe, rd_conflict, e_data, e_oe, e_err);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [2:0] a,
                           input logic [7:0] d, input int hold = 3);
    @(negedge clk);
    {sel_b_n, sel_a_n} = sel; addr = a; wdata = d; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    {sel_b_n, sel_a_n} = 2'b11;
  endtask

  task automatic bus_read(input logic [1:0] sel, input logic [2:0] a,
                          input logic [7:0] exp, input string req);
    @(negedge clk);
    {sel_b_n, sel_a_n} = sel; addr = a; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(rdata === exp, req, "read data", rdata, exp);
    chk(rdata_oe === (sel != 2'b11), req, "output enable", rdata_oe, sel != 2'b11);
    chk(rd_conflict === (sel == 2'b00), req, "conflict flag", rd_conflict, sel == 2'b00);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    {sel_b_n, sel_a_n} = 2'b11;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    mchk_on = 1;
    repeat (3) @(negedge clk);
    chk(rdata === 8'h00 && rdata_oe === 1'b0 && rd_conflict === 1'b0,
        "R10", "reset outputs", {rdata_oe, rd_conflict, rdata}, 0);

    cur_req = "R4";
    bus_read(2'b10, 3'd1, 8'h00, "R6");
    bus_write(2'b10, 3'd3, 8'h80);
    bus_read(2'b10, 3'd1, 8'h12, "R4");
    bus_read(2'b10, 3'd0, 8'h01, "R4");

    cur_req = "R5";
    bus_write(2'b10, 3'd0, 8'h34);
    bus_read(2'b10, 3'd0, 8'h34, "R5");
    bus_read(2'b10, 3'd1, 8'h00, "R5");

    cur_req = "R1";
    bus_write(2'b01, 3'd7, 8'h5A);
    bus_read(2'b01, 3'd7, 8'h5A, "R1");
    bus_read(2'b10, 3'd7, 8'h00, "R1");

    cur_req = "R2";
    bus_write(2'b00, 3'd7, 8'hC3);
    bus_read(2'b10, 3'd7, 8'hC3, "R2");
    bus_read(2'b01, 3'd7, 8'hC3, "R2");
    bus_write(2'b00, 3'd3, 8'h80);
    bus_read(2'b01, 3'd1, 8'h12, "R2");

    cur_req = "R3";
    bus_read(2'b00, 3'd7, 8'h00, "R3");

    cur_req = "R6";
    bus_write(2'b10, 3'd3, 8'h03);
    bus_write(2'b10, 3'd0, 8'h77);
    bus_write(2'b10, 3'd1, 8'h0F);
    bus_read(2'b10, 3'd0, 8'h77, "R6");
    bus_read(2'b10, 3'd1, 8'h0F, "R6");
    bus_read(2'b10, 3'd3, 8'h03, "R6");
    bus_write(2'b10, 3'd3, 8'h83);
    bus_read(2'b10, 3'd0, 8'h34, "R6");

    cur_req = "R11";
    bus_write(2'b10, 3'd5, 8'hFF);
    bus_read(2'b10, 3'd5, 8'h00, "R11");
    bus_read(2'b10, 3'd2, 8'h00, "R11");
    bus_read(2'b10, 3'd7, 8'hC3, "R11");

    cur_req = "R9";
    bus_write(2'b11, 3'd7, 8'h11);
    bus_read(2'b11, 3'd7, 8'h00, "R9");
    bus_read(2'b10, 3'd7, 8'hC3, "R9");
    bus_read(2'b01, 3'd7, 8'hC3, "R9");

    cur_req = "R7";
    bus_write(2'b01, 3'd7, 8'h9E, 8);
    bus_read(2'b01, 3'd7, 8'h9E, "R7");

    cur_req = "R8";
    @(negedge clk);
    {sel_b_n, sel_a_n} = 2'b01; addr = 3'd7; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(rdata === 8'h9E && rdata_oe === 1'b1, "R8", "early sample", rdata, 8'h9E);
    repeat (6) @(negedge clk);
    chk(rdata === 8'h9E && rdata_oe === 1'b1, "R8", "late sample", rdata, 8'h9E);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdata_oe === 1'b0 && rdata === 8'h00, "R8", "after release", {rdata_oe, rdata}, 0);
    {sel_b_n, sel_a_n} = 2'b11;

    cur_req = "R10";
    @(negedge clk); rst = 1'b1;
    repeat (RMIN - 1) @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(2'b10, 3'd7, 8'hC3, "R10");
    @(negedge clk); rst = 1'b1;
    repeat (RMIN) @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(2'b10, 3'd7, 8'h00, "R10");
    bus_read(2'b01, 3'd3, 8'h00, "R10");
    bus_write(2'b01, 3'd3, 8'h80);
    bus_read(2'b01, 3'd1, 8'h12, "R10");
    bus_read(2'b01, 3'd0, 8'h01, "R10");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule